// File: doc/BRIEF.md
# Masked LFSR Pseudonoise Bit Generator

This block produces a pseudonoise bit stream from a Fibonacci linear-feedback shift register. The feedback connections follow a degree-`DEG` generator polynomial fixed at elaboration. The polynomial's leading and constant coefficients are both 1. Each output bit is the parity of the register state ANDed with an output mask. Choosing the mask moves the stream's starting point along the sequence. The mask is either a parameter or a live input port, and an elaboration-time selector picks which.

The register advances only on cycles where the enable input is high. A synchronous restart input returns the register to its initial state and drops any partly built word. An optional packing stage collects `PACK_BITS` consecutive output bits into a word, with the earliest bit placed at the MSB. The word is also presented as a 32-bit value, sign-extended or zero-extended as selected. Typical uses are scrambling and spreading-code generation.

Top module: `pn_seq_gen`

## Requirements
- R1: With the mask equal to 1 at bit 0 only, `bit_o` equals the current register bit 0. The register recurrence is s[t+DEG] = XOR of s[t+k] over every k < DEG whose coefficient `POLY[k]` is 1, and register bit i holds s[t+i]. The default polynomial is z^8+z^4+z^3+z^2+1 with `POLY[0]`, `POLY[2]`, `POLY[3]` and `POLY[4]` set, and the default initial state is 8'h01.
- R2: While `en_i` is low and `restart_i` is low, the register holds its value, `bit_o` is unchanged and no word is produced.
- R3: `bit_o` is the XOR of all register bits whose mask bit is 1, formed from the state before the advance of the same cycle. A mask with only bit k set advances the stream by k positions.
- R4: With the mask source set to parameter (`MASK_FROM_PORT`=0), `mask_i` has no effect and the parameter mask `MASK_FIXED` is used.
- R5: `restart_i` high at a clock edge reloads the initial state even if `en_i` is high, so the sequence restarts from its first bit.
- R6: `restart_i` discards a partly collected word, and the next word holds the `PACK_BITS` bits produced after the restart.
- R7: After every `PACK_BITS` advances, `word_vld_o` is high for exactly one cycle, starting one cycle after the final advance. `word_o` then holds those bits, with the earliest bit at the MSB.
- R8: `word_ext_o` is `word_o` sign-extended to 32 bits when `PACK_SIGNED`=1 (MSB 1 means negative) and zero-extended when `PACK_SIGNED`=0.
- R9: While `rst_ni` is low, the register holds the initial state, the packing count is zero, `word_vld_o` is low and `word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the register and consume the current bit |
| restart_i | input | 1 | Synchronous reload of the initial state; takes priority over en_i |
| mask_i | input | DEG | Output mask, used when MASK_FROM_PORT=1 |
| bit_o | output | 1 | Masked pseudonoise bit for the current state |
| word_o | output | PACK_BITS | Packed word, earliest bit in the MSB |
| word_ext_o | output | 32 | Packed word extended to 32 bits, signed or unsigned |
| word_vld_o | output | 1 | One-cycle pulse when a new word is presented |

## Verification
Idle gaps test whether the register holds when the enable is low. A register that ignored the enable would drift away from the reference stream, and a packer that counted idle cycles would emit a word early. A restart placed in the middle of a word shows whether the partial count is cleared. A design that forgot to clear it would emit a word that mixes bits from before and after the restart. A restart raised together with the enable checks the priority rule: a design that advanced first would start one bit late. Nonzero masks on the port instance and a constant mask on a second instance check the tap selection and that the port is ignored. A second instance with a negative packed word catches missing sign extension.

// File: rtl/pn_seq_pkg.sv
package pn_seq_pkg;
  localparam int unsigned EXT_W = 32;

  typedef enum logic {
    MASK_SRC_FIXED = 1'b0,
    MASK_SRC_PORT  = 1'b1
  } mask_src_e;

  // Extend a packed word of width pw held in the low bits of w.
  function automatic logic [EXT_W-1:0] extend_word(input logic [EXT_W-1:0] w,
                                                   input int unsigned pw,
                                                   input logic is_signed);
    logic [EXT_W-1:0] r;
    for (int i = 0; i < EXT_W; i++) begin
      if (i < pw) r[i] = w[i];
      else        r[i] = is_signed & w[pw-1];
    end
    return r;
  endfunction
endpackage

// File: rtl/pn_lfsr_core.sv
module pn_lfsr_core #(
  parameter int unsigned DEG = 8,
  parameter logic [DEG:0] POLY = 9'h11D,
  parameter logic [DEG-1:0] INIT = 8'h01
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic           restart_i,
  output logic [DEG-1:0] state_o
);
  logic [DEG-1:0] state_q;
  logic           fb_w;

  // Taps below the leading term; bit 0 always participates.
  assign fb_w = ^(state_q & POLY[DEG-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= INIT;
    else if (restart_i) state_q <= INIT;
    else if (step_i)    state_q <= {fb_w, state_q[DEG-1:1]};
  end

  assign state_o = state_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !restart_i) |=> $stable(state_q));
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_q == INIT));
  a_r1_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i) |=> (state_q[DEG-2:0] == $past(state_q[DEG-1:1])));
endmodule

// File: rtl/pn_mask_tap.sv
module pn_mask_tap
  import pn_seq_pkg::*;
#(
  parameter int unsigned DEG = 8,
  parameter mask_src_e MASK_SRC = MASK_SRC_PORT,
  parameter logic [DEG-1:0] MASK_FIXED = 8'h01
) (
  input  logic [DEG-1:0] state_i,
  input  logic [DEG-1:0] mask_i,
  output logic           bit_o
);
  logic [DEG-1:0] mask_w;

  generate
    if (MASK_SRC == MASK_SRC_PORT) begin : g_port
      assign mask_w = mask_i;
    end else begin : g_fixed
      logic unused_mask;
      assign unused_mask = ^mask_i;
      assign mask_w = MASK_FIXED;
    end
  endgenerate

  assign bit_o = ^(state_i & mask_w);
endmodule

// File: rtl/pn_word_packer.sv
module pn_word_packer #(
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          restart_i,
  input  logic          bit_i,
  output logic [PW-1:0] word_o,
  output logic          vld_o
);
  localparam int unsigned CW = (PW > 1) ? $clog2(PW) : 1;
  localparam logic [CW-1:0] LAST = CW'(PW - 1);

  logic [PW-1:0] acc_q;
  logic [PW:0]   shift_w;
  logic [CW-1:0] cnt_q;

  assign shift_w = {acc_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (step_i) begin
        acc_q <= shift_w[PW-1:0];
        if (cnt_q == LAST) begin
          word_o <= shift_w[PW-1:0];
          vld_o  <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r6_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !vld_o);
  a_r7_idle_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i || restart_i) |=> !vld_o);

  generate
    if (PW > 1) begin : g_pulse_chk
      a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |=> !vld_o);
    end
  endgenerate
endmodule

// File: rtl/pn_seq_gen.sv
module pn_seq_gen
  import pn_seq_pkg::*;
#(
  parameter int unsigned DEG = 8,
  parameter logic [DEG:0] POLY = 9'h11D,
  parameter logic [DEG-1:0] INIT = 8'h01,
  parameter bit MASK_FROM_PORT = 1'b1,
  parameter logic [DEG-1:0] MASK_FIXED = 8'h01,
  parameter bit PACK_EN = 1'b1,
  parameter int unsigned PACK_BITS = 4,
  parameter bit PACK_SIGNED = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 restart_i,
  input  logic [DEG-1:0]       mask_i,
  output logic                 bit_o,
  output logic [PACK_BITS-1:0] word_o,
  output logic [EXT_W-1:0]     word_ext_o,
  output logic                 word_vld_o
);
  localparam mask_src_e MSRC = MASK_FROM_PORT ? MASK_SRC_PORT : MASK_SRC_FIXED;

  logic [DEG-1:0] state_w;

  pn_lfsr_core #(.DEG(DEG), .POLY(POLY), .INIT(INIT)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (en_i),
    .restart_i (restart_i),
    .state_o   (state_w)
  );

  pn_mask_tap #(.DEG(DEG), .MASK_SRC(MSRC), .MASK_FIXED(MASK_FIXED)) i_tap (
    .state_i (state_w),
    .mask_i  (mask_i),
    .bit_o   (bit_o)
  );

  generate
    if (PACK_EN) begin : g_pack
      logic [EXT_W-1:0] word_pad_w;
      pn_word_packer #(.PW(PACK_BITS)) i_pack (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (en_i),
        .restart_i (restart_i),
        .bit_i     (bit_o),
        .word_o    (word_o),
        .vld_o     (word_vld_o)
      );
      assign word_pad_w = EXT_W'(word_o);
      assign word_ext_o = extend_word(word_pad_w, PACK_BITS, PACK_SIGNED);
    end else begin : g_nopack
      assign word_o     = '0;
      assign word_ext_o = '0;
      assign word_vld_o = 1'b0;
    end
  endgenerate

  initial begin
    a_r1_params: assert (POLY[DEG] && POLY[0] && DEG >= 2 && INIT != '0);
    a_r7_pack_range: assert (PACK_BITS >= 1 && PACK_BITS <= 32);
  end
endmodule

// File: tb/test_pn_seq_gen.sv
module test_pn_seq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        rs = 1'b0;
  logic [7:0]  mk = 8'h01;
  logic        bit_a, bit_b, vld_a, vld_b;
  logic [3:0]  word_a, word_b;
  logic [31:0] ext_a, ext_b;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string wtag = "R7";

  logic [7:0]  m;
  logic [3:0]  acc_a, acc_b;
  int          cnt;
  logic [31:0] q_a[$];
  logic [31:0] q_b[$];

  always #5 clk = ~clk;

  pn_seq_gen i_pn_seq_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .restart_i(rs), .mask_i(mk),
    .bit_o(bit_a), .word_o(word_a), .word_ext_o(ext_a), .word_vld_o(vld_a)
  );

  pn_seq_gen #(.MASK_FROM_PORT(1'b0), .MASK_FIXED(8'h06), .PACK_SIGNED(1'b1)) i_pn_fixed (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .restart_i(rs), .mask_i(mk),
    .bit_o(bit_b), .word_o(word_b), .word_ext_o(ext_b), .word_vld_o(vld_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and updates the reference model.
  task automatic step(input bit e, input bit r, input logic [7:0] msk);
    logic ea, eb, fb;
    @(negedge clk);
    en = e; rs = r; mk = msk;
    #1;
    ea = ^(m & msk);
    eb = ^(m & 8'h06);
    chk(bit_a === ea, (msk != 8'h01) ? "R3" : (!e ? "R2" : "R1"), 32'(bit_a), 32'(ea));
    chk(bit_b === eb, "R4", 32'(bit_b), 32'(eb));
    @(posedge clk);
    if (r) begin
      m = 8'h01;
      cnt = 0;
    end else if (e) begin
      acc_a = {acc_a[2:0], ea};
      acc_b = {acc_b[2:0], eb};
      cnt++;
      if (cnt == 4) begin
        q_a.push_back({28'h0, acc_a});
        q_b.push_back({{28{acc_b[3]}}, acc_b});
        cnt = 0;
      end
      fb = m[0] ^ m[2] ^ m[3] ^ m[4];
      m = {fb, m[7:1]};
    end
  endtask

  // Monitor: compares presented words against the scoreboard queues.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && vld_a) begin
        if (q_a.size() == 0) chk(1'b0, "R7", {28'h0, word_a}, 32'hx);
        else begin
          logic [31:0] ex;
          ex = q_a.pop_front();
          chk(ext_a === ex && word_a === ex[3:0], wtag, ext_a, ex);
        end
      end
      if (rst_n && vld_b) begin
        if (q_b.size() == 0) chk(1'b0, "R8", ext_b, 32'hx);
        else begin
          logic [31:0] ex;
          ex = q_b.pop_front();
          chk(ext_b === ex, "R8", ext_b, ex);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m = 8'h01; acc_a = '0; acc_b = '0; cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(vld_a === 1'b0 && vld_b === 1'b0, "R9", 32'(vld_a), 32'h0);
    chk(word_a === 4'h0, "R9", 32'(word_a), 32'h0);
    chk(bit_a === 1'b1, "R9", 32'(bit_a), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 24; i++) step(1, 0, 8'h01);           // R1, R7
    for (int i = 0; i < 6; i++) step(0, 0, 8'h01);            // R2 idle gap
    for (int i = 0; i < 9; i++) step(i % 3 != 0, 0, 8'h01);   // R2 sparse enable
    for (int i = 0; i < 12; i++) step(1, 0, 8'h08);           // R3 shifted tap
    for (int i = 0; i < 12; i++) step(1, 0, 8'hA5);           // R3 multi-tap, R4 ignores
    while (cnt != 2) step(1, 0, 8'h01);
    // R6: restart in the middle of a word
    step(0, 1, 8'h01);
    wtag = "R6";
    for (int i = 0; i < 4; i++) step(1, 0, 8'h01);
    step(0, 0, 8'h01);
    wtag = "R7";
    for (int i = 0; i < 7; i++) step(1, 0, 8'h01);
    // R5: restart wins over enable
    step(1, 1, 8'h01);
    for (int i = 0; i < 8; i++) step(1, 0, 8'h01);
    for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, ($urandom % 97) == 0, 8'(1 << (i % 8)));
    for (int i = 0; i < 3; i++) step(0, 0, 8'h01);
    chk(q_a.size() == 0, "R7", q_a.size(), 0);
    chk(q_b.size() == 0, "R8", q_b.size(), 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule